// File: doc/BRIEF.md
# CAN Receive Error Counter

This block tracks how many receive errors a CAN node has accumulated and turns that level into status and interrupt flags. Three single-cycle error pulses come in: CRC failure, bit-stuffing violation and malformed frame. Each pulse raises an 8-bit count by one. A successful-reception pulse lowers the count by one. The count never drops below zero and never passes 255.

Two fixed thresholds on the count give a warning flag and an error-passive flag. Both follow the count level, so they fall again when the count falls back below the threshold. A sticky invalid-message flag records that an error pulse arrived during reception, and stays set until software clears it with a strobe. The error pulses never drive the interrupt line directly. A summary error interrupt is the OR of the three flags.

Top module: `can_rx_errcnt`

## Requirements
- R1: Each asserted bit of `err_pulse_i` (bit 0 = CRC error, bit 1 = stuffing error, bit 2 = invalid message) adds one to `rec_count_o`, so pulses in the same cycle add their number of set bits.
- R2: The count saturates at 255. Further errors leave it at 255 and it never wraps to a small value.
- R3: A cycle with `rx_ok_i` high lowers the count, after that cycle's errors are added, by one. A count that would go below zero stays at zero.
- R4: `warn_o` is high exactly when the count is 96 or more, and falls when the count drops back to 95.
- R5: `passive_o` is high exactly when the count is above 127, that is 128 or more. Whenever `passive_o` is high, `warn_o` is also high.
- R6: `inval_o` sets on any cycle with a nonzero `err_pulse_i` and then holds. `inval_clr_i` clears it. When a set and a clear arrive in the same cycle, the set wins.
- R7: `err_irq_o` is the OR of `warn_o`, `passive_o` and `inval_o`. An error pulse alone does not raise it in the cycle the pulse is applied.
- R8: Asserting `rst_n` low clears the count and every flag at once, without waiting for a clock edge.
- R9: Every output reflects a stimulus from the first rising clock edge at which that stimulus is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| err_pulse_i | input | 3 | Error pulses: bit 0 CRC, bit 1 stuffing, bit 2 invalid message |
| rx_ok_i | input | 1 | Successful-reception pulse |
| inval_clr_i | input | 1 | Software strobe that clears the invalid-message flag |
| rec_count_o | output | 8 | Receive error count |
| warn_o | output | 1 | Count has reached the warning level |
| passive_o | output | 1 | Node is in the error-passive state |
| inval_o | output | 1 | Sticky invalid-message flag |
| err_irq_o | output | 1 | Summary error interrupt |

## Verification
The count and the invalid-message flag are registered, so both are due on the first rising edge that samples a pulse or strobe. The warning, passive and interrupt outputs are decoded from those registers and change in that same cycle. The bench drives inputs on a falling edge, lets one rising edge pass, and samples every output on the next falling edge. For the same-cycle interrupt rule, it samples `err_irq_o` shortly after driving the pulse and before the rising edge. The asynchronous reset is sampled 1 ns after `rst_n` falls, with no clock edge in between.

// File: rtl/can_rx_errcnt_pkg.sv
package can_rx_errcnt_pkg;
  // Bit positions of the error pulse vector.
  typedef enum int unsigned {
    SRC_CRC   = 0,
    SRC_STUFF = 1,
    SRC_FORM  = 2
  } err_src_e;

  localparam int unsigned NUM_SRC = 3;

  typedef struct packed {
    logic warn;
    logic passive;
  } level_flags_t;
endpackage

// File: rtl/rec_counter.sv
module rec_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] err_i,
  input  logic               ok_i,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int unsigned N_W   = $clog2(NUM_SRC + 1);
  localparam int unsigned EXT_W = CNT_W + N_W;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [N_W-1:0]   n_err;
  logic [EXT_W-1:0] ext;
  logic             cnt_en;

  // Next-state: add the number of error pulses, then apply the decrement, then clamp.
  always_comb begin
    n_err = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      n_err = n_err + N_W'(err_i[i]);
    end
    ext = EXT_W'(cnt_q) + EXT_W'(n_err);
    if (ok_i && (ext != '0)) begin
      ext = ext - EXT_W'(1);
    end
    if (ext > EXT_W'(MAXV)) begin
      cnt_d = MAXV;
    end else begin
      cnt_d = ext[CNT_W-1:0];
    end
    cnt_en = (n_err != '0) || ok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R1: a single pulse below saturation adds exactly one
  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(err_i) == 1 && !ok_i && cnt_q != MAXV) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2: a saturated count stays saturated under further errors
  p_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !ok_i) |=> cnt_q == MAXV);

  // R3: a clean reception lowers a nonzero count by one
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_i && err_i == '0 && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R3: zero is a floor
  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_i && err_i == '0 && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/rec_level.sv
module rec_level
  import can_rx_errcnt_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WARN_LVL = 96,
  parameter int unsigned PASS_LVL = 127
) (
  input  logic [CNT_W-1:0] cnt_i,
  output level_flags_t     lvl_o
);
  // Level-following decode, recomputed from the count every cycle.
  always_comb begin
    lvl_o.warn    = cnt_i >= CNT_W'(WARN_LVL);
    lvl_o.passive = cnt_i >  CNT_W'(PASS_LVL);
  end
endmodule

// File: rtl/rec_sticky.sv
module rec_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d, q_en;

  always_comb begin
    q_en = set_i || clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  // R6: an error sets the flag, even against a clear strobe
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // R6: a lone clear strobe drops the flag
  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  // R6: with no strobe the flag holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/can_rx_errcnt.sv
module can_rx_errcnt
  import can_rx_errcnt_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WARN_LVL = 96,
  parameter int unsigned PASS_LVL = 127
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] err_pulse_i,
  input  logic               rx_ok_i,
  input  logic               inval_clr_i,
  output logic [CNT_W-1:0]   rec_count_o,
  output logic               warn_o,
  output logic               passive_o,
  output logic               inval_o,
  output logic               err_irq_o
);
  logic [CNT_W-1:0] cnt;
  level_flags_t     lvl;
  logic             any_err;
  logic             inval;

  assign any_err = |err_pulse_i;

  rec_counter #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .err_i (err_pulse_i),
    .ok_i  (rx_ok_i),
    .cnt_o (cnt)
  );

  rec_level #(.CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL)) u_lvl (
    .cnt_i (cnt),
    .lvl_o (lvl)
  );

  rec_sticky u_inval (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (any_err),
    .clr_i (inval_clr_i),
    .q_o   (inval)
  );

  assign rec_count_o = cnt;
  assign warn_o      = lvl.warn;
  assign passive_o   = lvl.passive;
  assign inval_o     = inval;
  assign err_irq_o   = lvl.warn | lvl.passive | inval;

  // R5: passive state implies the warning level
  p_pass_warn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    passive_o |-> warn_o);

  // R7: with all flags down and the count below warning, the interrupt stays low even during a pulse
  p_no_direct_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inval && rec_count_o < CNT_W'(WARN_LVL)) |-> !err_irq_o);
endmodule

// File: tb/can_rx_errcnt_test.sv
`timescale 1ns/1ps
module can_rx_errcnt_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] err = '0;
  logic       ok = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] cnt;
  logic       warn, pass, inval, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_rx_errcnt uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_pulse_i (err),
    .rx_ok_i     (ok),
    .inval_clr_i (clr),
    .rec_count_o (cnt),
    .warn_o      (warn),
    .passive_o   (pass),
    .inval_o     (inval),
    .err_irq_o   (irq)
  );

  // Vector: [16:14] err, [13] ok, [12] clr, [11:4] count, [3] warn, [2] passive, [1] inval, [0] irq
  localparam logic [16:0] VEC [12] = '{
    {3'b001, 1'b0, 1'b0, 8'd1, 4'b0011},
    {3'b000, 1'b0, 1'b1, 8'd1, 4'b0000},
    {3'b111, 1'b0, 1'b0, 8'd4, 4'b0011},
    {3'b000, 1'b1, 1'b1, 8'd3, 4'b0000},
    {3'b010, 1'b1, 1'b0, 8'd3, 4'b0011},
    {3'b000, 1'b0, 1'b1, 8'd3, 4'b0000},
    {3'b000, 1'b1, 1'b0, 8'd2, 4'b0000},
    {3'b000, 1'b1, 1'b0, 8'd1, 4'b0000},
    {3'b000, 1'b1, 1'b0, 8'd0, 4'b0000},
    {3'b000, 1'b1, 1'b0, 8'd0, 4'b0000},
    {3'b100, 1'b0, 1'b1, 8'd1, 4'b0011},
    {3'b000, 1'b0, 1'b1, 8'd1, 4'b0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge sample, return at the next falling edge.
  task automatic step(input logic [2:0] e, input logic o, input logic c);
    err = e; ok = o; clr = c;
    @(posedge clk);
    #1;
    err = '0; ok = 1'b0; clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_all(input string tag, input logic [7:0] c, input logic [3:0] f);
    chk({tag, " count"},   32'(cnt),   32'(c));
    chk({tag, " warn"},    32'(warn),  32'(f[3]));
    chk({tag, " passive"}, 32'(pass),  32'(f[2]));
    chk({tag, " inval"},   32'(inval), 32'(f[1]));
    chk({tag, " irq"},     32'(irq),   32'(f[0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R8 reset state", 8'd0, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R6 R7 R9: table walk
    foreach (VEC[i]) begin
      step(VEC[i][16:14], VEC[i][13], VEC[i][12]);
      chk_all($sformatf("R1/R3/R6/R9 vector %0d", i), VEC[i][11:4], VEC[i][3:0]);
    end

    // R4: approach the warning level
    for (int i = 0; i < 31; i++) step(3'b111, 1'b0, 1'b0);
    step(3'b001, 1'b0, 1'b0);
    chk("R4 count 95", 32'(cnt), 32'd95);
    chk("R4 warn low at 95", 32'(warn), 32'd0);
    step(3'b001, 1'b0, 1'b0);
    chk("R4 warn high at 96", 32'(warn), 32'd1);
    chk("R5 passive low at 96", 32'(pass), 32'd0);
    step(3'b000, 1'b1, 1'b0);
    chk("R4 warn follows count down to 95", 32'(warn), 32'd0);
    step(3'b000, 1'b0, 1'b1);
    chk("R7 irq low with flags low", 32'(irq), 32'd0);

    // R7: pulse alone does not raise the interrupt in its own cycle
    err = 3'b001;
    #1;
    chk("R7 no direct irq from pulse", 32'(irq), 32'd0);
    @(posedge clk);
    #1;
    err = '0;
    @(negedge clk);
    chk("R7 irq via flags after pulse", 32'(irq), 32'd1);
    step(3'b000, 1'b0, 1'b1);
    chk("R7 irq held by warn", 32'(irq), 32'd1);

    // R5: passive boundary
    for (int i = 0; i < 31; i++) step(3'b001, 1'b0, 1'b0);
    chk_all("R5 at 127", 8'd127, 4'b1011);
    step(3'b001, 1'b0, 1'b0);
    chk("R5 passive high at 128", 32'(pass), 32'd1);
    step(3'b000, 1'b1, 1'b0);
    chk("R5 passive low at 127", 32'(pass), 32'd0);

    // R2: saturation
    for (int i = 0; i < 43; i++) step(3'b111, 1'b0, 1'b0);
    chk("R2 saturate at 255", 32'(cnt), 32'd255);
    step(3'b111, 1'b0, 1'b0);
    chk("R2 no wrap", 32'(cnt), 32'd255);
    step(3'b111, 1'b1, 1'b0);
    chk("R2 R3 errors and ok at 255", 32'(cnt), 32'd255);
    step(3'b000, 1'b1, 1'b0);
    chk("R3 ok lowers 255", 32'(cnt), 32'd254);

    // R8: asynchronous reset mid run
    rst_n = 1'b0;
    #1;
    chk_all("R8 async reset", 8'd0, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R8 after release", 8'd0, 4'b0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule